// File: doc/BRIEF.md
# Temperature record and limit monitor

This block sits behind a temperature sampling sequencer. Each time the sequencer produces a new averaged reading it pulses a strobe with the value, a signed number in units of 1/256 degree Celsius. The block latches the reading, counts how many clock cycles old it is, and reports whether it is still fresh enough to use under a programmable validity time.

Alongside the stored reading it keeps a running highest and lowest value, each with its own clear pulse. Every reading is compared against an upper and lower interrupt limit. Sticky over and under flags and an interrupt flag are raised from that comparison. A second, independent pair of limits drives a level reset request while the stored reading is valid and out of range. All clear inputs are one-cycle write-one-to-clear pulses. When a flag is set and cleared in the same cycle, the set wins.

Top module: `temp_monitor`

## Requirements
- R1: After reset the stored reading, maximum, minimum, age, valid, all flags and both requests are 0. On the clock edge where `smp_stb` is 1, `temp_cur` takes `smp_data`.
- R2: `age` becomes 0 on a strobe edge and otherwise rises by 1 per clock. It holds at all ones (2^AGE_W-1) instead of wrapping.
- R3: `valid` becomes 1 on a strobe edge. On an edge without a strobe it becomes 0 when the new age value is greater than or equal to `valid_time`. It stays 0 until the next strobe.
- R4: `temp_max` holds the highest signed reading since reset or since the last `clr_max` pulse. The first reading after either is loaded unconditionally. A clear alone leaves the displayed value unchanged until the next reading.
- R5: `temp_min` behaves the same way for the lowest signed reading, with `clr_min`.
- R6: `over_flag` is set by a reading with `cmp_hi_en`=1 that is greater than `irq_hi` (signed). `under_flag` is set by a reading with `cmp_lo_en`=1 that is less than `irq_lo` (signed). Each flag stays set until its clear pulse (`clr_over`, `clr_under`).
- R7: When a set event and the matching clear pulse arrive on the same edge, the flag or recorder ends up set or loaded. The event is not lost.
- R8: `irq_flag` is set by a reading that sets either limit flag while `irq_en`=1. It clears on `clr_irq`. `irq` always equals `irq_flag`.
- R9: `rst_req` is 1 exactly when `rst_en`=1, `valid`=1, and the stored reading either exceeds `rst_hi` with `cmp_hi_en`=1 or is below `rst_lo` with `cmp_lo_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | New reading strobe |
| smp_data | input | 32 | New reading, signed, 1/256 degree C |
| valid_time | input | AGE_W | Cycles until a reading expires |
| cmp_hi_en | input | 1 | Enable upper-limit comparison |
| cmp_lo_en | input | 1 | Enable lower-limit comparison |
| irq_en | input | 1 | Interrupt enable |
| rst_en | input | 1 | Reset request enable |
| irq_hi | input | 32 | Upper interrupt limit, signed |
| irq_lo | input | 32 | Lower interrupt limit, signed |
| rst_hi | input | 32 | Upper reset limit, signed |
| rst_lo | input | 32 | Lower reset limit, signed |
| clr_over | input | 1 | Clear over flag |
| clr_under | input | 1 | Clear under flag |
| clr_irq | input | 1 | Clear interrupt flag |
| clr_max | input | 1 | Restart maximum recorder |
| clr_min | input | 1 | Restart minimum recorder |
| temp_cur | output | 32 | Stored reading |
| temp_max | output | 32 | Recorded maximum |
| temp_min | output | 32 | Recorded minimum |
| age | output | AGE_W | Cycles since stored reading |
| valid | output | 1 | Stored reading still usable |
| over_flag | output | 1 | Sticky over-limit flag |
| under_flag | output | 1 | Sticky under-limit flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request level |

## Verification
Random readings are drawn from a narrow signed band that straddles zero and all four limits, so that equal-to-limit readings occur. This separates strict from non-strict compares and signed from unsigned compares. Random enables, clear pulses and sparse strobes with short validity times exercise expiry, and they make clears collide with set events, which shows whether set takes priority. Directed cases cover the reset state, a recorder clear together with a reading, and a long idle stretch that drives the age into saturation.

// File: rtl/tm_pkg.sv
// Shared definitions for the temperature monitor.
// Assumes readings are signed two's complement in 1/256 degree units.
package tm_pkg;
    localparam int TEMP_W = 32;
    typedef logic signed [TEMP_W-1:0] temp_t;
endpackage

// File: rtl/tm_sample_store.sv
// Holds the latest reading, its age in clocks and its validity.
// Assumes smp_stb is a single-cycle pulse from the sequencer.
module tm_sample_store #(
    parameter int AGE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_stb,
    input  tm_pkg::temp_t      smp_data,
    input  logic [AGE_W-1:0]   valid_time,
    output tm_pkg::temp_t      temp_cur,
    output logic [AGE_W-1:0]   age,
    output logic               valid
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_nxt;

    // Saturating increment of the age counter.
    always_comb age_nxt = (age == AGE_MAX) ? AGE_MAX : age + 1'b1;

    // Latch reading, restart age, and expire validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_cur <= '0;
            age      <= '0;
            valid    <= 1'b0;
        end else if (smp_stb) begin
            temp_cur <= smp_data;
            age      <= '0;
            valid    <= 1'b1;
        end else begin
            age <= age_nxt;
            if (age_nxt >= valid_time) valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tm_recorder.sv
// Extreme-value recorder; IS_MAX picks highest or lowest tracking.
// Assumes a clear restarts tracking: the next reading loads directly.
module tm_recorder #(
    parameter bit IS_MAX = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  tm_pkg::temp_t smp_data,
    input  logic          clr,
    output tm_pkg::temp_t rec
);
    logic seen;
    logic better;

    // Compare direction chosen at elaboration.
    generate
        if (IS_MAX) begin : g_max
            always_comb better = smp_data > rec;
        end else begin : g_min
            always_comb better = smp_data < rec;
        end
    endgenerate

    // Load on first reading after restart or on a new extreme.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec  <= '0;
            seen <= 1'b0;
        end else if (smp_stb && (!seen || clr || better)) begin
            rec  <= smp_data;
            seen <= 1'b1;
        end else if (clr) begin
            seen <= 1'b0;
        end
    end
endmodule

// File: rtl/tm_limit_check.sv
// Limit comparisons, sticky flags and the reset request level.
// Assumes set events take priority over same-cycle clear pulses.
module tm_limit_check (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  tm_pkg::temp_t smp_data,
    input  tm_pkg::temp_t temp_cur,
    input  logic          valid,
    input  logic          cmp_hi_en,
    input  logic          cmp_lo_en,
    input  logic          irq_en,
    input  logic          rst_en,
    input  tm_pkg::temp_t irq_hi,
    input  tm_pkg::temp_t irq_lo,
    input  tm_pkg::temp_t rst_hi,
    input  tm_pkg::temp_t rst_lo,
    input  logic          clr_over,
    input  logic          clr_under,
    input  logic          clr_irq,
    output logic          over_flag,
    output logic          under_flag,
    output logic          irq_flag,
    output logic          rst_req
);
    logic hit_hi, hit_lo, set_irq;

    // Interrupt-limit events for the incoming reading.
    always_comb begin
        hit_hi  = smp_stb && cmp_hi_en && (smp_data > irq_hi);
        hit_lo  = smp_stb && cmp_lo_en && (smp_data < irq_lo);
        set_irq = irq_en && (hit_hi || hit_lo);
    end

    // Sticky flags with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_flag  <= 1'b0;
            under_flag <= 1'b0;
            irq_flag   <= 1'b0;
        end else begin
            if (hit_hi)        over_flag  <= 1'b1;
            else if (clr_over) over_flag  <= 1'b0;
            if (hit_lo)         under_flag <= 1'b1;
            else if (clr_under) under_flag <= 1'b0;
            if (set_irq)      irq_flag <= 1'b1;
            else if (clr_irq) irq_flag <= 1'b0;
        end
    end

    // Reset request from the stored, still valid reading.
    always_comb
        rst_req = rst_en && valid &&
                  ((cmp_hi_en && (temp_cur > rst_hi)) ||
                   (cmp_lo_en && (temp_cur < rst_lo)));
endmodule

// File: rtl/temp_monitor.sv
// Top of the temperature record and limit monitor.
// Assumes all clears are single-cycle write-one-to-clear pulses.
module temp_monitor #(
    parameter int AGE_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            smp_stb,
    input  logic signed [tm_pkg::TEMP_W-1:0] smp_data,
    input  logic [AGE_W-1:0]                valid_time,
    input  logic                            cmp_hi_en,
    input  logic                            cmp_lo_en,
    input  logic                            irq_en,
    input  logic                            rst_en,
    input  logic signed [tm_pkg::TEMP_W-1:0] irq_hi,
    input  logic signed [tm_pkg::TEMP_W-1:0] irq_lo,
    input  logic signed [tm_pkg::TEMP_W-1:0] rst_hi,
    input  logic signed [tm_pkg::TEMP_W-1:0] rst_lo,
    input  logic                            clr_over,
    input  logic                            clr_under,
    input  logic                            clr_irq,
    input  logic                            clr_max,
    input  logic                            clr_min,
    output logic signed [tm_pkg::TEMP_W-1:0] temp_cur,
    output logic signed [tm_pkg::TEMP_W-1:0] temp_max,
    output logic signed [tm_pkg::TEMP_W-1:0] temp_min,
    output logic [AGE_W-1:0]                age,
    output logic                            valid,
    output logic                            over_flag,
    output logic                            under_flag,
    output logic                            irq_flag,
    output logic                            irq,
    output logic                            rst_req
);
    tm_sample_store #(.AGE_W(AGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .valid_time(valid_time), .temp_cur(temp_cur), .age(age), .valid(valid)
    );

    tm_recorder #(.IS_MAX(1'b1)) u_rec_max (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .clr(clr_max), .rec(temp_max)
    );

    tm_recorder #(.IS_MAX(1'b0)) u_rec_min (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .clr(clr_min), .rec(temp_min)
    );

    tm_limit_check u_lim (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .temp_cur(temp_cur), .valid(valid),
        .cmp_hi_en(cmp_hi_en), .cmp_lo_en(cmp_lo_en),
        .irq_en(irq_en), .rst_en(rst_en),
        .irq_hi(irq_hi), .irq_lo(irq_lo), .rst_hi(rst_hi), .rst_lo(rst_lo),
        .clr_over(clr_over), .clr_under(clr_under), .clr_irq(clr_irq),
        .over_flag(over_flag), .under_flag(under_flag),
        .irq_flag(irq_flag), .rst_req(rst_req)
    );

    // Interrupt line follows the sticky flag.
    always_comb irq = irq_flag;
endmodule

// File: rtl/tm_checker.sv
// Protocol checks for temp_monitor, attached by bind.
module tm_checker #(
    parameter int AGE_W = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             smp_stb,
    input logic signed [tm_pkg::TEMP_W-1:0] smp_data,
    input logic                             cmp_hi_en,
    input logic                             irq_en,
    input logic                             rst_en,
    input logic signed [tm_pkg::TEMP_W-1:0] irq_hi,
    input logic                             clr_over,
    input logic signed [tm_pkg::TEMP_W-1:0] temp_cur,
    input logic signed [tm_pkg::TEMP_W-1:0] temp_max,
    input logic signed [tm_pkg::TEMP_W-1:0] temp_min,
    input logic [AGE_W-1:0]                 age,
    input logic                             valid,
    input logic                             over_flag,
    input logic                             irq_flag,
    input logic                             rst_req
);
    a_r2_age_restart: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (age == '0) && valid && (temp_cur == $past(smp_data)));
    a_r3_expire_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> !$past(smp_stb));
    a_r4_max_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> temp_max >= temp_cur);
    a_r5_min_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> temp_min <= temp_cur);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && cmp_hi_en && (smp_data > irq_hi) && clr_over) |=> over_flag);
    a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && irq_en && cmp_hi_en && (smp_data > irq_hi)) |=> irq_flag);
    a_r9_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_en && valid));
endmodule

bind temp_monitor tm_checker #(.AGE_W(AGE_W)) u_tm_checker (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .cmp_hi_en(cmp_hi_en), .irq_en(irq_en), .rst_en(rst_en), .irq_hi(irq_hi),
    .clr_over(clr_over), .temp_cur(temp_cur), .temp_max(temp_max),
    .temp_min(temp_min), .age(age), .valid(valid), .over_flag(over_flag),
    .irq_flag(irq_flag), .rst_req(rst_req)
);

// File: tb/tb_temp_monitor.sv
module tb_temp_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam logic [AW-1:0] AMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 0;
    logic signed [31:0] smp_data = 0;
    logic [AW-1:0] valid_time = 0;
    logic cmp_hi_en = 0, cmp_lo_en = 0, irq_en = 0, rst_en = 0;
    logic signed [31:0] irq_hi = 0, irq_lo = 0, rst_hi = 0, rst_lo = 0;
    logic clr_over = 0, clr_under = 0, clr_irq = 0, clr_max = 0, clr_min = 0;
    logic signed [31:0] temp_cur, temp_max, temp_min;
    logic [AW-1:0] age;
    logic valid, over_flag, under_flag, irq_flag, irq, rst_req;

    int total = 0;
    int bad = 0;

    // Reference model state.
    logic signed [31:0] m_cur, m_max, m_min;
    logic [AW-1:0] m_age;
    logic m_valid, m_maxs, m_mins, m_over, m_under, m_irq;

    temp_monitor #(.AGE_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .valid_time(valid_time), .cmp_hi_en(cmp_hi_en), .cmp_lo_en(cmp_lo_en),
        .irq_en(irq_en), .rst_en(rst_en), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .rst_hi(rst_hi), .rst_lo(rst_lo), .clr_over(clr_over),
        .clr_under(clr_under), .clr_irq(clr_irq), .clr_max(clr_max),
        .clr_min(clr_min), .temp_cur(temp_cur), .temp_max(temp_max),
        .temp_min(temp_min), .age(age), .valid(valid), .over_flag(over_flag),
        .under_flag(under_flag), .irq_flag(irq_flag), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic signed [31:0] act, logic signed [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_rst();
        return rst_en && m_valid &&
               ((cmp_hi_en && (m_cur > rst_hi)) || (cmp_lo_en && (m_cur < rst_lo)));
    endfunction

    task automatic model_reset();
        m_cur = 0; m_max = 0; m_min = 0; m_age = 0; m_valid = 0;
        m_maxs = 0; m_mins = 0; m_over = 0; m_under = 0; m_irq = 0;
    endtask

    task automatic model_step();
        logic [AW-1:0] an;
        logic ov, un;
        ov = smp_stb && cmp_hi_en && (smp_data > irq_hi);
        un = smp_stb && cmp_lo_en && (smp_data < irq_lo);
        if (smp_stb && (!m_maxs || clr_max || smp_data > m_max)) begin
            m_max = smp_data; m_maxs = 1;
        end else if (clr_max) m_maxs = 0;
        if (smp_stb && (!m_mins || clr_min || smp_data < m_min)) begin
            m_min = smp_data; m_mins = 1;
        end else if (clr_min) m_mins = 0;
        if (ov) m_over = 1; else if (clr_over) m_over = 0;
        if (un) m_under = 1; else if (clr_under) m_under = 0;
        if (irq_en && (ov || un)) m_irq = 1; else if (clr_irq) m_irq = 0;
        if (smp_stb) begin
            m_cur = smp_data; m_age = 0; m_valid = 1;
        end else begin
            an = (m_age == AMAX) ? AMAX : m_age + 1'b1;
            if (an >= valid_time) m_valid = 0;
            m_age = an;
        end
    endtask

    task automatic compare_all();
        chk("R1 temp_cur", temp_cur, m_cur);
        chk("R2 age", {26'd0, age}, {26'd0, m_age});
        chk("R3 valid", {31'd0, valid}, {31'd0, m_valid});
        chk("R4 temp_max", temp_max, m_max);
        chk("R5 temp_min", temp_min, m_min);
        chk("R6 over_flag", {31'd0, over_flag}, {31'd0, m_over});
        chk("R6 under_flag", {31'd0, under_flag}, {31'd0, m_under});
        chk("R8 irq_flag", {31'd0, irq_flag}, {31'd0, m_irq});
        chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
        chk("R9 rst_req", {31'd0, rst_req}, {31'd0, exp_rst()});
    endtask

    // One clock: inputs already set, model and compare after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        compare_all();
        smp_stb = 0; clr_over = 0; clr_under = 0; clr_irq = 0;
        clr_max = 0; clr_min = 0;
    endtask

    function automatic logic signed [31:0] rnd_temp();
        return $signed($urandom_range(800, 0)) - 400;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare_all();            // R1 reset state
        rst_n = 1;
        irq_hi = 100; irq_lo = -100; rst_hi = 200; rst_lo = -200;
        valid_time = 8;
        cmp_hi_en = 1; cmp_lo_en = 1; irq_en = 1; rst_en = 1;

        // R4/R5 first reading loads both recorders; R6/R8 sets.
        smp_stb = 1; smp_data = 250; tick();
        smp_stb = 1; smp_data = -250; tick();
        // R7: clears colliding with set events.
        smp_stb = 1; smp_data = 101; clr_over = 1; clr_irq = 1; clr_max = 1; tick();
        chk("R7 over kept", {31'd0, over_flag}, 32'd1);
        chk("R7 max reloaded", temp_max, 32'sd101);
        // Equality at limits sets nothing new.
        clr_over = 1; clr_under = 1; clr_irq = 1; tick();
        smp_stb = 1; smp_data = 100; tick();
        smp_stb = 1; smp_data = -100; tick();
        chk("R6 equal limit no flag", {31'd0, over_flag | under_flag}, 32'd0);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 100) < 5) begin
                irq_hi = rnd_temp(); irq_lo = rnd_temp();
                rst_hi = rnd_temp(); rst_lo = rnd_temp();
                valid_time = AW'($urandom_range(20, 0));
                cmp_hi_en = $urandom % 2; cmp_lo_en = $urandom % 2;
                irq_en = $urandom % 2; rst_en = $urandom % 2;
            end
            smp_stb = (($urandom % 100) < 15);
            smp_data = (($urandom % 8) == 0) ? irq_hi : rnd_temp();
            clr_over = (($urandom % 100) < 6);
            clr_under = (($urandom % 100) < 6);
            clr_irq = (($urandom % 100) < 6);
            clr_max = (($urandom % 100) < 3);
            clr_min = (($urandom % 100) < 3);
            tick();
        end

        // R2 saturation: long idle stretch.
        valid_time = 5; smp_stb = 1; smp_data = 7; tick();
        repeat (70) tick();
        chk("R2 age saturated", {26'd0, age}, {26'd0, AMAX});
        chk("R3 expired", {31'd0, valid}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule